// File: doc/BRIEF.md
# ADC Result FIFO with Coding

This block sits between a 12-bit successive-approximation converter and a host register port. Each time the converter strobes a completed result, the block recodes it into a 16-bit word and appends it to a 512-word first-in first-out store. A mode input selects the coding. In unsigned mode the 12-bit value is zero-extended. In signed mode the top converter bit is inverted to give two's complement, and the result is sign-extended.

The host sees the oldest stored word on a read-data port at all times. It pops that word with a one-cycle read pulse. A data-available output tells the host when a word is present. Two sticky error flags record lost data. The overflow flag is set when a result arrives with nowhere to go. The overrun flag is set when a new conversion is requested while the previous one is still busy.

A one-cycle clear pulse empties the store and clears both flags. It then leaves exactly one word in the store: the most recent coded conversion. All strobes are single-cycle pulses in the block's clock domain. Reset is synchronous.

Top module: `adc_result_fifo`

## Requirements
- R1: With `bipolar` low, a stored word equals the 12-bit result with four zero bits above it (for example, 0xABC is stored as 0x0ABC).
- R2: With `bipolar` high, bit 11 of the result is inverted and that inverted bit fills bits 15..12. For example, 0x000 gives 0xF800, 0x800 gives 0x0000, 0xFFF gives 0x07FF and 0x7FF gives 0xFFFF.
- R3: Words leave in the order they were stored, and up to 512 words can be held at once.
- R4: `data_avail` is high exactly when at least one word is stored.
- R5: A completion that arrives while 512 words are stored, with no read in the same cycle, is dropped and sets `overflow_err`. The stored words are unchanged, and the flag stays set until a clear.
- R6: A completion and a read in the same cycle on a full store are both accepted, and neither one sets `overflow_err`.
- R7: `start_req` while `conv_busy` is high sets `overrun_err`, which stays set until a clear. `start_req` with `conv_busy` low leaves the flag unchanged.
- R8: After a clear, exactly one word is stored and both error flags are low. That word is the last coded conversion, or the coded result of a completion that arrives in the same cycle as the clear. A clear overrides any error or read in the same cycle.
- R9: A read pulse while the store is empty has no effect. The next stored word is the next word presented.
- R10: After reset the store is empty, both flags are low, and the held last-value word is 0x0000, so a clear right after reset leaves one word 0x0000.
- R11: `rd_word` shows the oldest word without waiting for a clock edge. A read pulse presents the following word from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_done | input | 1 | One-cycle pulse: conversion result valid |
| conv_code | input | 12 | Raw converter result |
| bipolar | input | 1 | 1 = two's-complement coding, 0 = straight binary |
| start_req | input | 1 | One-cycle pulse: new conversion requested |
| conv_busy | input | 1 | Converter still working on the previous conversion |
| host_rd | input | 1 | One-cycle pulse: pop the oldest word |
| host_clr | input | 1 | One-cycle pulse: clear store and flags, reload last value |
| rd_word | output | 16 | Oldest stored word |
| data_avail | output | 1 | At least one word is stored |
| overflow_err | output | 1 | Sticky: a result was lost to a full store |
| overrun_err | output | 1 | Sticky: a start request hit a busy converter |

## Verification
Two pairs of events can land in the same cycle and interact. The first pair is a completion and a host read while the store holds 512 words. The bench fills the store to exactly 512 words, then issues both pulses together, and expects the flag to stay low and the order to hold as the store drains. The second pair is a completion and a clear. The bench pulses both at once and expects the freshly coded word, not the older held value, to be the single word left, with both flags low. Random traffic with phases of slow and fast reading repeats both collisions, and a reference queue judges every cycle.

// File: rtl/adcf_pkg.sv
package adcf_pkg;

    typedef enum logic {
        CODE_STRAIGHT = 1'b0,
        CODE_TWOS     = 1'b1
    } code_mode_e;

    typedef struct packed {
        logic ovf;
        logic ovr;
    } err_flags_t;

endpackage

// File: rtl/adcf_coder.sv
module adcf_coder #(
    parameter int RES  = 12,
    parameter int WORD = 16
) (
    input  logic [RES-1:0]    raw,
    input  adcf_pkg::code_mode_e mode,
    output logic [WORD-1:0]   word
);
    localparam int EXT = WORD - RES;

    logic [RES-1:0] recoded;
    logic           fill_bit;

    always_comb begin
        recoded  = raw;
        fill_bit = 1'b0;
        if (mode == adcf_pkg::CODE_TWOS) begin
            recoded[RES-1] = ~raw[RES-1];
            fill_bit       = ~raw[RES-1];
        end
    end

    generate
        if (EXT > 0) begin : g_extend
            assign word = {{EXT{fill_bit}}, recoded};
        end else begin : g_flat
            assign word = recoded[WORD-1:0];
        end
    endgenerate

endmodule

// File: rtl/adcf_buffer.sv
module adcf_buffer #(
    parameter int WORD  = 16,
    parameter int DEPTH = 512
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic [WORD-1:0] push_word,
    input  logic            pop,
    input  logic            flush,
    input  logic [WORD-1:0] flush_word,
    output logic [WORD-1:0] head,
    output logic            empty,
    output logic            drop
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] rd_ptr;
        logic [AW-1:0] wr_ptr;
        logic [CW-1:0] count;
    } buf_state_t;

    buf_state_t st_d, st_q;
    logic [WORD-1:0] mem [DEPTH];

    logic            full;
    logic            pop_ok;
    logic            push_ok;
    logic            wr_en;
    logic [WORD-1:0] wr_data;

    always_comb begin
        full    = (st_q.count == FULL_CNT);
        empty   = (st_q.count == '0);
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
        drop    = push && full && !pop_ok && !flush;
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_data = push_word;
        if (flush) begin
            wr_en       = 1'b1;
            wr_data     = flush_word;
            st_d.rd_ptr = st_q.wr_ptr;
            st_d.wr_ptr = st_q.wr_ptr + AW'(1);
            st_d.count  = CW'(1);
        end else begin
            if (pop_ok) begin
                st_d.rd_ptr = st_q.rd_ptr + AW'(1);
            end
            if (push_ok) begin
                wr_en       = 1'b1;
                st_d.wr_ptr = st_q.wr_ptr + AW'(1);
            end
            if (push_ok && !pop_ok) begin
                st_d.count = st_q.count + CW'(1);
            end else if (pop_ok && !push_ok) begin
                st_d.count = st_q.count - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[st_q.wr_ptr] <= wr_data;
        end
    end

    assign head = mem[st_q.rd_ptr];

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        st_q.count <= FULL_CNT); // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> (st_q.count == FULL_CNT)); // R5
    AST_FULL_RDWR: assert property (@(posedge clk) disable iff (rst)
        (full && push && pop && !flush) |=> (st_q.count == FULL_CNT && !$past(drop))); // R6
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push && !flush) |=> empty); // R9
    AST_FLUSH_ONE: assert property (@(posedge clk) disable iff (rst)
        flush |=> (st_q.count == CW'(1))); // R8

endmodule

// File: rtl/adcf_errors.sv
module adcf_errors (
    input  logic                clk,
    input  logic                rst,
    input  logic                ovf_evt,
    input  logic                ovr_evt,
    input  logic                clr,
    output adcf_pkg::err_flags_t flags
);
    adcf_pkg::err_flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (clr) begin
            fl_d = '0;
        end else begin
            if (ovf_evt) fl_d.ovf = 1'b1;
            if (ovr_evt) fl_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags = fl_q;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fl_q.ovf && !clr) |=> fl_q.ovf); // R5
    AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
        (ovr_evt && !clr) |=> fl_q.ovr); // R7
    AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!fl_q.ovf && !fl_q.ovr)); // R8

endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo #(
    parameter int RES   = 12,
    parameter int WORD  = 16,
    parameter int DEPTH = 512
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            conv_done,
    input  logic [RES-1:0]  conv_code,
    input  logic            bipolar,
    input  logic            start_req,
    input  logic            conv_busy,
    input  logic            host_rd,
    input  logic            host_clr,
    output logic [WORD-1:0] rd_word,
    output logic            data_avail,
    output logic            overflow_err,
    output logic            overrun_err
);
    typedef struct packed {
        logic [WORD-1:0] last;
    } top_state_t;

    top_state_t ts_d, ts_q;

    logic [WORD-1:0]      coded;
    logic [WORD-1:0]      reload;
    logic                 buf_empty;
    logic                 buf_drop;
    adcf_pkg::err_flags_t flags;
    adcf_pkg::code_mode_e mode;

    assign mode = bipolar ? adcf_pkg::CODE_TWOS : adcf_pkg::CODE_STRAIGHT;

    adcf_coder #(.RES(RES), .WORD(WORD)) coder_i (
        .raw  (conv_code),
        .mode (mode),
        .word (coded)
    );

    always_comb begin
        ts_d = ts_q;
        if (conv_done) begin
            ts_d.last = coded;
        end
        reload = conv_done ? coded : ts_q.last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_q <= '0;
        end else begin
            ts_q <= ts_d;
        end
    end

    adcf_buffer #(.WORD(WORD), .DEPTH(DEPTH)) buffer_i (
        .clk        (clk),
        .rst        (rst),
        .push       (conv_done),
        .push_word  (coded),
        .pop        (host_rd),
        .flush      (host_clr),
        .flush_word (reload),
        .head       (rd_word),
        .empty      (buf_empty),
        .drop       (buf_drop)
    );

    adcf_errors errors_i (
        .clk     (clk),
        .rst     (rst),
        .ovf_evt (buf_drop),
        .ovr_evt (start_req && conv_busy),
        .clr     (host_clr),
        .flags   (flags)
    );

    assign data_avail   = !buf_empty;
    assign overflow_err = flags.ovf;
    assign overrun_err  = flags.ovr;

    AST_CLR_AVAIL: assert property (@(posedge clk) disable iff (rst)
        host_clr |=> (data_avail && rd_word == $past(reload))); // R8
    AST_LAST_HELD: assert property (@(posedge clk) disable iff (rst)
        !conv_done |=> $stable(ts_q.last)); // R8

endmodule

// File: tb/adc_result_fifo_tb_top.sv
`timescale 1ns/1ps
module adc_result_fifo_tb_top;
    localparam int DEPTH = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_done = 1'b0;
    logic [11:0] conv_code = '0;
    logic        bipolar = 1'b0;
    logic        start_req = 1'b0;
    logic        conv_busy = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_clr = 1'b0;
    logic [15:0] rd_word;
    logic        data_avail;
    logic        overflow_err;
    logic        overrun_err;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] mq[$];
    logic [15:0] m_last = '0;
    logic        m_ovf = 1'b0;
    logic        m_ovr = 1'b0;

    always #5 clk = ~clk;

    adc_result_fifo dut_i (
        .clk(clk), .rst(rst), .conv_done(conv_done), .conv_code(conv_code),
        .bipolar(bipolar), .start_req(start_req), .conv_busy(conv_busy),
        .host_rd(host_rd), .host_clr(host_clr), .rd_word(rd_word),
        .data_avail(data_avail), .overflow_err(overflow_err),
        .overrun_err(overrun_err)
    );

    function automatic logic [15:0] code_of(input logic [11:0] raw, input logic bp);
        logic [11:0] v;
        if (!bp) return {4'h0, raw};
        v = raw ^ 12'h800;
        return {{4{v[11]}}, v};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic cyc(input logic cd, input logic [11:0] cc, input logic bp,
                       input logic sr, input logic cb, input logic rd, input logic cl);
        logic [15:0] w;
        logic        pop;
        conv_done = cd; conv_code = cc; bipolar = bp;
        start_req = sr; conv_busy = cb; host_rd = rd; host_clr = cl;
        @(posedge clk);
        w = code_of(cc, bp);
        if (cl) begin
            mq.delete();
            mq.push_back(cd ? w : m_last);
            m_ovf = 1'b0;
            m_ovr = 1'b0;
        end else begin
            pop = rd && (mq.size() > 0);
            if (pop) void'(mq.pop_front());
            if (cd) begin
                if (mq.size() >= DEPTH) m_ovf = 1'b1;
                else mq.push_back(w);
            end
            if (sr && cb) m_ovr = 1'b1;
        end
        if (cd) m_last = w;
        @(negedge clk);
        conv_done = 1'b0; start_req = 1'b0; host_rd = 1'b0; host_clr = 1'b0;
        chk("R4", data_avail, mq.size() != 0);
        chk("R5", overflow_err, m_ovf);
        chk("R7", overrun_err, m_ovr);
        if (mq.size() != 0) chk("R3", rd_word, mq[0]);
    endtask

    task automatic push(input logic [11:0] raw, input logic bp);
        cyc(1'b1, raw, bp, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic pop1();
        cyc(1'b0, 12'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [11:0] braw [5];
        logic [15:0] bexp [5];
        int unsigned seed;
        seed = $urandom(32'd20240611);
        braw = '{12'h000, 12'h800, 12'hFFF, 12'h7FF, 12'h001};
        bexp = '{16'hF800, 16'h0000, 16'h07FF, 16'hFFFF, 16'hF801};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R10", data_avail, 1'b0);
        chk("R10", overflow_err, 1'b0);
        chk("R10", overrun_err, 1'b0);

        // R10: clear right after reset reloads a zero word
        cyc(1'b0, 12'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R10", rd_word, 16'h0000);
        chk("R8", data_avail, 1'b1);
        pop1();
        chk("R4", data_avail, 1'b0);

        // R1: straight binary
        push(12'hABC, 1'b0);
        chk("R1", rd_word, 16'h0ABC);
        pop1();

        // R2: two's complement, sign extended
        for (int i = 0; i < 5; i++) begin
            push(braw[i], 1'b1);
            chk("R2", rd_word, bexp[i]);
            pop1();
        end

        // R11: head visible before the edge, next word after it
        push(12'h111, 1'b0);
        push(12'h222, 1'b0);
        host_rd = 1'b1;
        #1;
        chk("R11", rd_word, 16'h0111);
        cyc(1'b0, 12'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R11", rd_word, 16'h0222);
        pop1();

        // R9: read on empty has no effect
        pop1();
        pop1();
        push(12'h333, 1'b0);
        chk("R9", rd_word, 16'h0333);
        chk("R9", data_avail, 1'b1);

        // clear reloads last value 0x0333, then fill to 512
        cyc(1'b0, 12'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R8", rd_word, 16'h0333);
        for (int i = 1; i < DEPTH; i++) push(12'(i), 1'b0);
        chk("R3", overflow_err, 1'b0);

        // R6: full, completion and read together
        cyc(1'b1, 12'h555, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R6", overflow_err, 1'b0);
        chk("R6", rd_word, 16'h0001);

        // R5: 513th result dropped
        push(12'hFFF, 1'b0);
        chk("R5", overflow_err, 1'b1);
        chk("R5", rd_word, 16'h0001);
        cyc(1'b0, 12'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R5", overflow_err, 1'b1);
        for (int i = 0; i < DEPTH; i++) pop1();
        chk("R3", data_avail, 1'b0);

        // R7: overrun
        cyc(1'b0, 12'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R7", overrun_err, 1'b0);
        cyc(1'b0, 12'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R7", overrun_err, 1'b1);
        cyc(1'b0, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R7", overrun_err, 1'b1);

        // R8: clear with a simultaneous completion and error
        cyc(1'b1, 12'h123, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        chk("R8", rd_word, 16'hF923);
        chk("R8", overrun_err, 1'b0);
        chk("R8", overflow_err, 1'b0);
        pop1();
        cyc(1'b0, 12'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R8", rd_word, 16'hF923);
        pop1();

        // random traffic in slow and fast read phases
        for (int ph = 0; ph < 8; ph++) begin
            for (int k = 0; k < 900; k++) begin
                logic cd, sr, cb, rd, cl, bp;
                logic [11:0] cc;
                cd = ($urandom % 4) != 0;
                cc = 12'($urandom);
                bp = 1'($urandom);
                sr = ($urandom % 8) == 0;
                cb = 1'($urandom);
                rd = (ph % 2 == 0) ? (($urandom % 8) == 0) : (($urandom % 4) != 0);
                cl = ($urandom % 700) == 0;
                cyc(cd, cc, bp, sr, cb, rd, cl);
            end
        end

        summary();
        $finish;
    end

endmodule